// File: doc/BRIEF.md
# Configuration Readback Command Sequencer

This block runs a complete frame readback over a 32-bit parallel configuration port. A single-cycle start request launches a fixed script of write words: bus-width detection and synchronization, a shutdown command, a CRC reset, a readback-configuration command, a frame-address load and the two read request headers. The script ends with a block of no-op padding. The sequencer then turns the port around to read, pulls a fixed number of words and forwards each one on a streaming output that the consumer can stall. It finishes by turning the port back to write and sending trailing no-ops.

The number of words to read is a parameter. That number is placed in the count field of the bulk read header and also sets how many read strobes are issued. The port is always driven from exactly one side. Whenever the direction flips, there is one cycle with no strobe at all. The bitstream content is not interpreted, and no CRC is checked on the returned words.

Top module: `cfg_readback_seq`

## Requirements
- R1: While reset is held, `busy`, `done`, `port_wr_en`, `port_rd_en` and `rb_valid` are 0, and `port_dir` is 1 (1 = the block drives the port, 0 = the port is read).
- R2: A `start` seen while idle makes the block write, one word per cycle from the next cycle, FFFFFFFF, 000000BB, 11220044, FFFFFFFF, AA995566.
- R3: The following writes are 20000000 (no-op), 30008001, 0000000B, 20000000, 30008001, 00000007, five no-ops, 30008001, 00000004, 20000000.
- R4: Next come 30002001, the frame address `FRAME_ADDR`, 28006000, and a read header whose bits [31:27] are 01001, whose bits [26:0] equal `RD_WORDS`, and whose other bits are 0.
- R5: `PAD_NOPS` no-ops follow the read header. The first read strobe comes exactly two cycles after the last header write. A write strobe appears only with `port_dir`=1, a read strobe only with `port_dir`=0, and a cycle in which `port_dir` changes carries no strobe.
- R6: Exactly `RD_WORDS` read strobes are issued. The `port_din` value present in each strobe cycle appears in order on `rb_data`, and `rb_last` is 1 on the final word only.
- R7: No read strobe is issued while a stream word is held with `rb_ready` low. A held word keeps its value until it is accepted, and no word is lost or repeated.
- R8: After the last read strobe, the first tail write comes exactly two cycles later. `TAIL_NOPS` no-ops (20000000) are then written.
- R9: `busy` is high from the cycle after the accepted `start` until `done`. `done` is a one-cycle pulse, issued only after all tail writes and after the last stream word has been accepted.
- R10: A `start` raised while busy has no effect. The write script and read count stay unchanged, and no extra run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a readback run (used only when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| port_dout | output | 32 | Word driven to the configuration port |
| port_wr_en | output | 1 | Write strobe for `port_dout` |
| port_rd_en | output | 1 | Read strobe; `port_din` is taken in this cycle |
| port_dir | output | 1 | 1 = block drives the port, 0 = port is read |
| port_din | input | 32 | Word returned by the configuration port |
| rb_data | output | 32 | Readback word on the stream |
| rb_valid | output | 1 | `rb_data` holds a word |
| rb_last | output | 1 | Final readback word |
| rb_ready | input | 1 | Consumer accepts the held word |

## Verification
The reference model holds the whole expected write script as a queue and pops one entry per write strobe. A misplaced, missing or extra command word or no-op therefore shows up as a mismatch or a write against an empty queue. The bench measures both turnaround gaps and flags any strobe in a cycle where the direction flips; a design that flipped direction in the same cycle as a strobe would drive the bus from both sides. A second run stalls the stream in a repeating pattern and pulses `start` mid-run. A design that read during a stall would overwrite a held word and show up as wrong or missing stream data. A design that restarted on the extra `start` would emit a second script. Finishing before the last stream word drains would produce an early `done`.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_TURN_RD,
        S_READ,
        S_TURN_WR,
        S_TAIL,
        S_FIN
    } seq_state_e;

    localparam logic [31:0] W_DUMMY      = 32'hFFFF_FFFF;
    localparam logic [31:0] W_WIDTH_SYNC = 32'h0000_00BB;
    localparam logic [31:0] W_WIDTH_DET  = 32'h1122_0044;
    localparam logic [31:0] W_SYNC       = 32'hAA99_5566;
    localparam logic [31:0] W_NOP        = 32'h2000_0000;
    localparam logic [31:0] W_CMD_HDR    = 32'h3000_8001;
    localparam logic [31:0] C_SHUTDOWN   = 32'h0000_000B;
    localparam logic [31:0] C_CRC_RST    = 32'h0000_0007;
    localparam logic [31:0] C_RB_CFG     = 32'h0000_0004;
    localparam logic [31:0] W_FA_HDR     = 32'h3000_2001;
    localparam logic [31:0] W_RD_HDR     = 32'h2800_6000;
    localparam logic [4:0]  T2_RD_TOP    = 5'b01001;

    localparam int FIXED_WORDS = 23;

endpackage

// File: rtl/cfgrb_cmd_rom.sv
module cfgrb_cmd_rom
    import cfgrb_pkg::*;
#(
    parameter int          IDX_W      = 6,
    parameter int          RD_WORDS   = 16,
    parameter logic [31:0] FRAME_ADDR = 32'h0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [31:0]      word_o
);

    always_comb begin
        case (int'(idx_i))
            0:       word_o = W_DUMMY;
            1:       word_o = W_WIDTH_SYNC;
            2:       word_o = W_WIDTH_DET;
            3:       word_o = W_DUMMY;
            4:       word_o = W_SYNC;
            6:       word_o = W_CMD_HDR;
            7:       word_o = C_SHUTDOWN;
            9:       word_o = W_CMD_HDR;
            10:      word_o = C_CRC_RST;
            16:      word_o = W_CMD_HDR;
            17:      word_o = C_RB_CFG;
            19:      word_o = W_FA_HDR;
            20:      word_o = FRAME_ADDR;
            21:      word_o = W_RD_HDR;
            22:      word_o = {T2_RD_TOP, 27'(RD_WORDS)};
            default: word_o = W_NOP;
        endcase
    end

endmodule

// File: rtl/cfgrb_out_reg.sv
module cfgrb_out_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_data_i,
    input  logic          ld_last_i,
    input  logic          ready_i,
    output logic          room_o,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic          last_o
);

    typedef struct packed {
        logic          valid;
        logic          last;
        logic [DW-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    assign room_o  = !slot_q.valid || ready_i;
    assign data_o  = slot_q.data;
    assign valid_o = slot_q.valid;
    assign last_o  = slot_q.last;

    always_comb begin
        slot_d = slot_q;
        if (ld_i) begin
            slot_d.valid = 1'b1;
            slot_d.last  = ld_last_i;
            slot_d.data  = ld_data_i;
        end else if (ready_i) begin
            slot_d.valid = 1'b0;
            slot_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o))); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |-> (!valid_o || ready_i)); // R7
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R6

endmodule

// File: rtl/cfg_readback_seq.sv
module cfg_readback_seq
    import cfgrb_pkg::*;
#(
    parameter int          RD_WORDS   = 16,
    parameter int          PAD_NOPS   = 32,
    parameter int          TAIL_NOPS  = 4,
    parameter logic [31:0] FRAME_ADDR = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic [31:0] port_dout,
    output logic        port_wr_en,
    output logic        port_rd_en,
    output logic        port_dir,
    input  logic [31:0] port_din,
    output logic [31:0] rb_data,
    output logic        rb_valid,
    output logic        rb_last,
    input  logic        rb_ready
);

    localparam int HEAD_LEN = FIXED_WORDS + PAD_NOPS;
    localparam int IDX_MAX  = (HEAD_LEN > TAIL_NOPS) ? HEAD_LEN : TAIL_NOPS;
    localparam int IDX_W    = $clog2(IDX_MAX);
    localparam int CNT_W    = (RD_WORDS > 1) ? $clog2(RD_WORDS) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] rcnt;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    logic [31:0] rom_word;
    logic        room;
    logic        rd_last;

    cfgrb_cmd_rom #(
        .IDX_W      (IDX_W),
        .RD_WORDS   (RD_WORDS),
        .FRAME_ADDR (FRAME_ADDR)
    ) i_rom (
        .idx_i  (s_q.idx),
        .word_o (rom_word)
    );

    assign port_rd_en = (s_q.st == S_READ) && room;
    assign rd_last    = (s_q.rcnt == CNT_W'(RD_WORDS - 1));

    cfgrb_out_reg #(.DW(32)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (port_rd_en),
        .ld_data_i (port_din),
        .ld_last_i (rd_last),
        .ready_i   (rb_ready),
        .room_o    (room),
        .data_o    (rb_data),
        .valid_o   (rb_valid),
        .last_o    (rb_last)
    );

    assign port_wr_en = (s_q.st == S_HDR) || (s_q.st == S_TAIL);
    assign port_dout  = (s_q.st == S_HDR) ? rom_word : W_NOP;
    assign port_dir   = !((s_q.st == S_TURN_RD) || (s_q.st == S_READ));
    assign busy       = (s_q.st != S_IDLE);
    assign done       = s_q.done;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st  = S_HDR;
                    s_d.idx = '0;
                end
            end
            S_HDR: begin
                if (s_q.idx == IDX_W'(HEAD_LEN - 1)) begin
                    s_d.st  = S_TURN_RD;
                    s_d.idx = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            S_TURN_RD: begin
                s_d.st   = S_READ;
                s_d.rcnt = '0;
            end
            S_READ: begin
                if (port_rd_en) begin
                    if (rd_last) s_d.st   = S_TURN_WR;
                    else         s_d.rcnt = s_q.rcnt + 1'b1;
                end
            end
            S_TURN_WR: begin
                s_d.st  = S_TAIL;
                s_d.idx = '0;
            end
            S_TAIL: begin
                if (s_q.idx == IDX_W'(TAIL_NOPS - 1)) s_d.st  = S_FIN;
                else                                  s_d.idx = s_q.idx + 1'b1;
            end
            S_FIN: begin
                if (!rb_valid) begin
                    s_d.st   = S_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: S_IDLE, idx: '0, rcnt: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_en |-> port_dir); // R5
    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_en |-> !port_dir); // R5
    AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (port_dir != $past(port_dir)) |-> (!port_wr_en && !port_rd_en)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rb_valid && !busy)); // R9

endmodule

// File: tb/test_cfg_readback_seq.sv
`timescale 1ns/1ps
module test_cfg_readback_seq;

    localparam int          NRD  = 10;
    localparam int          NPAD = 32;
    localparam int          NTL  = 4;
    localparam logic [31:0] FA   = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic        busy, done, port_wr_en, port_rd_en, port_dir;
    logic [31:0] port_dout, port_din, rb_data;
    logic        rb_valid, rb_last, rb_ready;

    always #5 clk = ~clk;

    cfg_readback_seq #(
        .RD_WORDS(NRD), .PAD_NOPS(NPAD), .TAIL_NOPS(NTL), .FRAME_ADDR(FA)
    ) i_cfg_readback_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .port_dout(port_dout), .port_wr_en(port_wr_en), .port_rd_en(port_rd_en),
        .port_dir(port_dir), .port_din(port_din), .rb_data(rb_data),
        .rb_valid(rb_valid), .rb_last(rb_last), .rb_ready(rb_ready)
    );

    int tests = 0;
    int fails = 0;

    logic [31:0] exp_wr[$];
    logic [31:0] exp_rb[$];
    int  ready_mode = 0;
    int  cyc = 0, last_wr_cyc = 0, last_rd_cyc = 0;
    int  reads_seen = 0, pops = 0, dones = 0, wr_idx = 0;
    bit  tail_started = 0, rd_pending = 0;
    int  rdk = 0;
    logic prev_dir = 1'b1;

    function automatic logic [31:0] rdval(int k);
        return 32'h5A00_0000 ^ (32'(k) * 32'h0103_0507);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic build_exp();
        exp_wr.delete();
        exp_wr.push_back(32'hFFFF_FFFF); exp_wr.push_back(32'h0000_00BB);
        exp_wr.push_back(32'h1122_0044); exp_wr.push_back(32'hFFFF_FFFF);
        exp_wr.push_back(32'hAA99_5566);
        exp_wr.push_back(32'h2000_0000);
        exp_wr.push_back(32'h3000_8001); exp_wr.push_back(32'h0000_000B);
        exp_wr.push_back(32'h2000_0000);
        exp_wr.push_back(32'h3000_8001); exp_wr.push_back(32'h0000_0007);
        for (int i = 0; i < 5; i++) exp_wr.push_back(32'h2000_0000);
        exp_wr.push_back(32'h3000_8001); exp_wr.push_back(32'h0000_0004);
        exp_wr.push_back(32'h2000_0000);
        exp_wr.push_back(32'h3000_2001); exp_wr.push_back(FA);
        exp_wr.push_back(32'h2800_6000);
        exp_wr.push_back(32'h4800_0000 | 32'(NRD));
        for (int i = 0; i < NPAD; i++) exp_wr.push_back(32'h2000_0000);
        for (int i = 0; i < NTL; i++)  exp_wr.push_back(32'h2000_0000);
    endtask

    function automatic string wr_req(int i);
        if (i < 5)  return "R2";
        if (i < 19) return "R3";
        if (i < 23) return "R4";
        if (i < 23 + NPAD) return "R5";
        return "R8";
    endfunction

    // per-cycle reference model
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ready_mode == 0) rb_ready = 1'b1;
            else                 rb_ready = !((cyc % 7) == 2 || (cyc % 7) == 3 || (cyc % 7) == 4);
            #1;
            if (port_dir !== prev_dir)
                chk(!port_wr_en && !port_rd_en, "R5", "strobe while direction flips",
                    {30'b0, port_wr_en, port_rd_en}, 32'h0);
            prev_dir = port_dir;
            if (port_wr_en) begin
                chk(port_dir === 1'b1, "R5", "write while not driving", 32'(port_dir), 32'h1);
                if (reads_seen == NRD && !tail_started) begin
                    tail_started = 1;
                    chk(cyc - last_rd_cyc == 2, "R8", "read-to-tail gap",
                        32'(cyc - last_rd_cyc), 32'd2);
                end
                if (exp_wr.size() == 0) begin
                    chk(0, "R10", "unexpected write", port_dout, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_wr.pop_front();
                    chk(port_dout === e, wr_req(wr_idx), "write word", port_dout, e);
                    wr_idx++;
                end
                last_wr_cyc = cyc;
            end
            if (port_rd_en) begin
                chk(port_dir === 1'b0, "R5", "read while driving", 32'(port_dir), 32'h0);
                chk(!rb_valid || rb_ready, "R7", "read into stalled slot",
                    32'(rb_valid), 32'h0);
                if (reads_seen == 0)
                    chk(cyc - last_wr_cyc == 2, "R5", "header-to-read gap",
                        32'(cyc - last_wr_cyc), 32'd2);
                chk(reads_seen < NRD, "R6", "read count", 32'(reads_seen + 1), 32'(NRD));
                exp_rb.push_back(port_din);
                reads_seen++;
                rd_pending = 1;
                last_rd_cyc = cyc;
            end
            if (rb_valid && rb_ready) begin
                logic [31:0] e;
                e = (exp_rb.size() != 0) ? exp_rb.pop_front() : 32'hDEAD_DEAD;
                pops++;
                chk(rb_data === e, "R6", "stream word", rb_data, e);
                chk(rb_last === (pops == NRD), "R6", "stream last flag",
                    32'(rb_last), 32'(pops == NRD));
            end
            if (done) begin
                dones++;
                chk(exp_wr.size() == 0, "R9", "done before tail complete",
                    32'(exp_wr.size()), 32'h0);
                chk(pops == NRD, "R9", "done before stream drained", 32'(pops), 32'(NRD));
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (rd_pending) begin
            rdk++;
            rd_pending = 0;
        end
        port_din = rdval(rdk);
    end

    task automatic run_seq(int mode, bit poke);
        int n;
        ready_mode = mode;
        build_exp();
        exp_rb.delete();
        rdk = 0; reads_seen = 0; pops = 0; dones = 0; wr_idx = 0; tail_started = 0;
        @(negedge clk); #2; start = 1'b1;
        @(negedge clk); #2; start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after start", 32'(busy), 32'h1);
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk); #2;
            n++;
            start = (poke && n == 30) ? 1'b1 : 1'b0;
            if (!done) chk(busy === 1'b1, "R9", "busy during run", 32'(busy), 32'h1);
        end
        start = 1'b0;
        if (n >= 3000) chk(0, "R9", "watchdog expired", 32'(n), 32'd3000);
        chk(reads_seen == NRD, "R6", "total reads", 32'(reads_seen), 32'(NRD));
        chk(pops == NRD, "R6", "total stream words", 32'(pops), 32'(NRD));
        repeat (8) @(negedge clk);
        #2;
        chk(busy === 1'b0, "R10", "idle after run", 32'(busy), 32'h0);
        chk(dones == 1, "R10", "done pulse count", 32'(dones), 32'h1);
        chk(exp_wr.size() == 0, "R8", "tail writes", 32'(exp_wr.size()), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; port_din = 32'h0; rb_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(busy === 1'b0 && done === 1'b0, "R1", "status in reset",
            {30'b0, busy, done}, 32'h0);
        chk(port_wr_en === 1'b0 && port_rd_en === 1'b0, "R1", "strobes in reset",
            {30'b0, port_wr_en, port_rd_en}, 32'h0);
        chk(rb_valid === 1'b0, "R1", "stream in reset", 32'(rb_valid), 32'h0);
        chk(port_dir === 1'b1, "R1", "direction in reset", 32'(port_dir), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        run_seq(0, 1'b0);
        run_seq(1, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        tests++;
        $display("FAIL R9 global watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule